// File: doc/BRIEF.md
# Serial Flash Boot Header Reader

This block is the flash-facing master of a boot path. When it is started, it fetches the boot header from a serial NOR flash and hands each header byte to the next stage on a one-cycle byte stream. It generates the flash chip select and serial clock itself, and it drives the command line.

The block first probes a fixed width-detection word. It sends a plain read, at the slow clock rate, for the four bytes at address 0x000020. The reply arrives one bit at a time on lane 1.

- If the four bytes equal the expected signature, the header is read with the quad-output read command at the fast clock rate. That read has a dummy window, and the data comes in on all four lanes.
- If the bytes do not match, a failure flag is raised. The header is then read with the plain read command at the slow rate.

Either way, the header runs from address 0x00001D up to and including 0x000045, which is 41 bytes in one transaction. A done pulse marks the end.

Top module: `flash_boot_reader`

## Requirements
- R1: A one-cycle `start` in idle launches a probe transaction: opcode 0x03, then the 24-bit address 0x000020, as 32 bits MSB first on `d_out[0]`.
- R2: The probe reply is four bytes, each taken MSB first from `d_in[1]`. `quad_mode` goes high after the probe only if the bytes are 0x66, 0x55, 0x99, 0xAA, in that order.
- R3: After a matching probe, the header transaction sends opcode 0x6B and address 0x00001D on `d_out[0]`. It then gives exactly 8 dummy clocks, and then samples each byte as two nibbles from `d_in[3:0]`, high nibble first, with `d_in[3]` the most significant bit.
- R4: The header bytes for addresses 0x1D through 0x45 inclusive (41 bytes) appear in ascending address order. Each appears as a one-cycle `hdr_valid` with its value on `hdr_byte`, and probe bytes never appear on the stream.
- R5: After a probe that does not match, `sig_fail` goes high and `quad_mode` stays low. The header is then read with opcode 0x03 at address 0x00001D, one bit at a time from `d_in[1]`.
- R6: `sclk` idles low. `d_out[0]` changes only while `sclk` is low or on a falling edge, and never on a rising edge or while `sclk` is high.
- R7: `cs_n` stays low for the whole of each transaction. Between the probe and the header it stays high for at least two half periods of the slow rate, and `sclk` is low whenever `cs_n` is high.
- R8: Each `sclk` high phase lasts div+1 clock cycles. The divider value is `div_slow` for the probe and for a single-lane header, and `div_fast` for a quad header.
- R9: `done` is a single-cycle pulse, with `cs_n` high, once the header transaction has ended. A `start` while a read is in progress is ignored.
- R10: While `rst_n` is low at a clock edge, the block returns to idle: `cs_n` high, `sclk` low, `d_oe` zero, and `hdr_valid`, `done`, `quad_mode` and `sig_fail` all low.
- R11: `d_oe` is 0001 exactly from the fall of `cs_n` through the high phase of the 32nd clock. After that it is 0000, so all lanes are released for the dummy and data phases, and bits 3..1 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a boot header fetch (taken only in idle) |
| div_slow | input | 8 | Half-period minus one for the probe and for single-lane reads |
| div_fast | input | 8 | Half-period minus one for quad header reads |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Flash serial clock |
| d_out | output | 4 | Values driven onto the flash data lanes |
| d_oe | output | 4 | Per-lane output enable |
| d_in | input | 4 | Values read back from the flash data lanes |
| hdr_valid | output | 1 | One-cycle strobe for a header byte |
| hdr_byte | output | 8 | Header byte, valid with `hdr_valid` |
| quad_mode | output | 1 | Probe matched; the header is read on four lanes |
| sig_fail | output | 1 | Probe did not match; single-lane fallback used |
| done | output | 1 | One-cycle pulse when the header fetch is finished |

## Verification
The bench spoils the probe reply in its last byte in one case and in its first byte in another. An order-blind or partial compare would then wrongly pick quad mode and garble the header.

It runs divider values of zero, where a rate switch taken at the wrong transaction shows up as a wrong high-phase length. It also counts how many data bytes follow the 8 dummy clocks, so an off-by-one in the dummy window or in nibble order shows up as shifted header bytes.

It checks that the command lane is released right after the 32nd clock, that a mid-run `start` does not restart the fetch, and that a reset in the middle of a transaction returns every output to idle.

// File: rtl/fbr_pkg.sv
// Package for the flash boot reader: flash opcodes and controller state types.
// Assumes 8-bit opcodes and 24-bit addressing on the flash side.
package fbr_pkg;
    localparam int OP_W = 8;
    localparam logic [OP_W-1:0] OP_READ_1X  = 8'h03;
    localparam logic [OP_W-1:0] OP_READ_4X  = 8'h6B;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP,
        ST_DONE
    } fbr_state_t;

    typedef enum logic {
        PH_PROBE,
        PH_HEADER
    } fbr_phase_t;
endpackage

// File: rtl/fbr_clkdiv.sv
// Half-period tick generator for the serial clock.
// While en is high it pulses tick once every div+1 cycles; it restarts when en drops.
// Assumes div is held stable except in the cycle that follows a tick.
module fbr_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    // Count cycles within one half period; wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/fbr_sigcheck.sv
// Width-detection word comparator.
// Compares the first NBYTES bytes after clear against WORD, first byte in the top bits.
// match is high only once every byte has arrived and all of them were equal.
module fbr_sigcheck #(
    parameter int NBYTES = 4,
    parameter logic [8*NBYTES-1:0] WORD = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       vld,
    input  logic [7:0] val,
    output logic       match
);
    localparam int CNT_W = $clog2(NBYTES + 1);

    logic [CNT_W-1:0] seen;
    logic             all_eq;
    logic [7:0]       want;

    // Pick the expected byte for the current position.
    always_comb begin
        want = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (seen == CNT_W'(i)) want = WORD[8*(NBYTES-1-i) +: 8];
        end
    end

    // Track position and a sticky equality flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen   <= '0;
            all_eq <= 1'b1;
        end else if (vld && seen < CNT_W'(NBYTES)) begin
            seen <= seen + 1'b1;
            if (val != want) all_eq <= 1'b0;
        end
    end

    assign match = all_eq && (seen == CNT_W'(NBYTES));
endmodule

// File: rtl/fbr_deser.sv
// Byte assembler for flash read data.
// On each smp it takes one bit from lanes[1] (single) or a nibble from lanes[3:0] (quad),
// MSB first, and emits a one-cycle vld with the finished byte. clr drops a partial byte.
module fbr_deser #(
    parameter int LANES = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              smp,
    input  logic              quad,
    input  logic [LANES-1:0]  lanes,
    output logic              vld,
    output logic [BYTE_W-1:0] data
);
    localparam int BC_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] acc, acc_nx;
    logic [BC_W-1:0]   nbits, nbits_nx;

    // Shift the next bit or nibble into the accumulator.
    always_comb begin
        acc_nx   = quad ? {acc[BYTE_W-LANES-1:0], lanes} : {acc[BYTE_W-2:0], lanes[1]};
        nbits_nx = nbits + (quad ? BC_W'(LANES) : BC_W'(1));
    end

    // Accumulate and release whole bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc   <= '0;
            nbits <= '0;
            vld   <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (smp) begin
                if (nbits_nx == BC_W'(BYTE_W)) begin
                    vld   <= 1'b1;
                    acc   <= '0;
                    nbits <= '0;
                end else begin
                    acc   <= acc_nx;
                    nbits <= nbits_nx;
                end
            end
        end
    end

    // Hold the last finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) data <= '0;
        else if (smp && !clr && nbits_nx == BC_W'(BYTE_W)) data <= acc_nx;
    end
endmodule

// File: rtl/flash_boot_reader.sv
// Boot header fetch master for a serial NOR flash.
// Probes a width-detection word at the slow rate on one lane. It then reads the header range
// either on four lanes (quad read with dummy clocks, fast rate) or on one lane (on mismatch).
// Serial clock idles low: lane 0 changes on falling edges and data is sampled on rising edges.
module flash_boot_reader
    import fbr_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int ADDR_W     = 24,
    parameter int PROBE_ADDR = 32'h20,
    parameter int HDR_FIRST  = 32'h1D,
    parameter int HDR_LAST   = 32'h45,
    parameter int DUMMY_CLKS = 8,
    parameter int SIG_BYTES  = 4,
    parameter logic [8*SIG_BYTES-1:0] SIG_WORD = 32'h665599AA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_slow,
    input  logic [DIV_W-1:0] div_fast,
    output logic             cs_n,
    output logic             sclk,
    output logic [3:0]       d_out,
    output logic [3:0]       d_oe,
    input  logic [3:0]       d_in,
    output logic             hdr_valid,
    output logic [7:0]       hdr_byte,
    output logic             quad_mode,
    output logic             sig_fail,
    output logic             done
);
    localparam int CMD_BITS  = OP_W + ADDR_W;
    localparam int HDR_BYTES = HDR_LAST - HDR_FIRST + 1;
    localparam int MAX_EDGES = CMD_BITS + DUMMY_CLKS + 8 * HDR_BYTES;
    localparam int EDGE_W    = $clog2(MAX_EDGES + 1);
    localparam logic [EDGE_W-1:0] CMD_END   = EDGE_W'(CMD_BITS);
    localparam logic [EDGE_W-1:0] PROBE_END = EDGE_W'(CMD_BITS + 8 * SIG_BYTES);
    localparam logic [EDGE_W-1:0] S_HDR_END = EDGE_W'(CMD_BITS + 8 * HDR_BYTES);
    localparam logic [EDGE_W-1:0] Q_DATA    = EDGE_W'(CMD_BITS + DUMMY_CLKS);
    localparam logic [EDGE_W-1:0] Q_HDR_END = EDGE_W'(CMD_BITS + DUMMY_CLKS + 2 * HDR_BYTES);
    localparam logic [ADDR_W-1:0] PROBE_A   = ADDR_W'(PROBE_ADDR);
    localparam logic [ADDR_W-1:0] HDR_A     = ADDR_W'(HDR_FIRST);

    fbr_state_t          st;
    fbr_phase_t          phase;
    logic                cs_q, sclk_q, cmd_oe, quad_rx, gap_q;
    logic                quad_q, fail_q;
    logic [CMD_BITS-1:0] sreg;
    logic [EDGE_W-1:0]   edges, end_edge, data_edge;
    logic [DIV_W-1:0]    div_q;
    logic                tick, smp, rx_vld, sig_ok;
    logic [7:0]          rx_byte;

    fbr_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(st == ST_XFER || st == ST_GAP), .div(div_q), .tick(tick)
    );

    assign smp = tick && (st == ST_XFER) && !sclk_q && (edges >= data_edge);

    fbr_deser #(.LANES(4), .BYTE_W(8)) u_deser (
        .clk(clk), .rst_n(rst_n), .clr(cs_q), .smp(smp), .quad(quad_rx),
        .lanes(d_in), .vld(rx_vld), .data(rx_byte)
    );

    fbr_sigcheck #(.NBYTES(SIG_BYTES), .WORD(SIG_WORD)) u_sig (
        .clk(clk), .rst_n(rst_n), .clear(st == ST_IDLE), .vld(rx_vld && phase == PH_PROBE),
        .val(rx_byte), .match(sig_ok)
    );

    // Sequence probe, gap, header, gap, done; toggle the serial clock on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            phase     <= PH_PROBE;
            cs_q      <= 1'b1;
            sclk_q    <= 1'b0;
            sreg      <= '0;
            edges     <= '0;
            end_edge  <= '0;
            data_edge <= '0;
            cmd_oe    <= 1'b0;
            quad_rx   <= 1'b0;
            div_q     <= '0;
            gap_q     <= 1'b0;
            quad_q    <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st        <= ST_XFER;
                        phase     <= PH_PROBE;
                        quad_q    <= 1'b0;
                        fail_q    <= 1'b0;
                        cs_q      <= 1'b0;
                        sclk_q    <= 1'b0;
                        edges     <= '0;
                        cmd_oe    <= 1'b1;
                        sreg      <= {OP_READ_1X, PROBE_A};
                        div_q     <= div_slow;
                        end_edge  <= PROBE_END;
                        data_edge <= CMD_END;
                        quad_rx   <= 1'b0;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            edges  <= edges + 1'b1;
                        end else if (edges == end_edge) begin
                            sclk_q <= 1'b0;
                            cs_q   <= 1'b1;
                            cmd_oe <= 1'b0;
                            gap_q  <= 1'b0;
                            st     <= ST_GAP;
                        end else begin
                            sclk_q <= 1'b0;
                            sreg   <= {sreg[CMD_BITS-2:0], 1'b0};
                            if (edges == CMD_END) cmd_oe <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        gap_q <= 1'b1;
                        if (gap_q) begin
                            if (phase == PH_PROBE) begin
                                st     <= ST_XFER;
                                phase  <= PH_HEADER;
                                cs_q   <= 1'b0;
                                sclk_q <= 1'b0;
                                edges  <= '0;
                                cmd_oe <= 1'b1;
                                if (sig_ok) begin
                                    sreg      <= {OP_READ_4X, HDR_A};
                                    div_q     <= div_fast;
                                    data_edge <= Q_DATA;
                                    end_edge  <= Q_HDR_END;
                                    quad_rx   <= 1'b1;
                                    quad_q    <= 1'b1;
                                end else begin
                                    sreg      <= {OP_READ_1X, HDR_A};
                                    div_q     <= div_slow;
                                    data_edge <= CMD_END;
                                    end_edge  <= S_HDR_END;
                                    quad_rx   <= 1'b0;
                                    fail_q    <= 1'b1;
                                end
                            end else begin
                                st <= ST_DONE;
                            end
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cs_n      = cs_q;
    assign sclk      = sclk_q;
    assign d_out     = {3'b000, sreg[CMD_BITS-1]};
    assign d_oe      = {3'b000, cmd_oe};
    assign hdr_valid = rx_vld && (phase == PH_HEADER);
    assign hdr_byte  = rx_byte;
    assign quad_mode = quad_q;
    assign sig_fail  = fail_q;
    assign done      = (st == ST_DONE);

    a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r6_d0_still_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(sclk)) |-> $stable(d_out[0]));
    a_r11_oe_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (|d_oe) |-> !cs_n);
    a_r9_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);
    a_r5_fail_not_quad: assert property (@(posedge clk) disable iff (!rst_n)
        sig_fail |-> !quad_mode);
    a_r4_byte_inside_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (!cs_n && sclk));
endmodule

// File: tb/flash_boot_reader_test.sv
// Bench for flash_boot_reader with a behavioural flash stub on the serial pins.
module flash_boot_reader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] div_slow = 8'd1, div_fast = 8'd0;
    logic       cs_n, sclk, hdr_valid, quad_mode, sig_fail, done;
    logic [3:0] d_out, d_oe;
    logic [3:0] d_in = 4'h0;
    logic [7:0] hdr_byte;

    always #2.5 clk = ~clk;

    flash_boot_reader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .div_slow(div_slow), .div_fast(div_fast),
        .cs_n(cs_n), .sclk(sclk), .d_out(d_out), .d_oe(d_oe), .d_in(d_in),
        .hdr_valid(hdr_valid), .hdr_byte(hdr_byte), .quad_mode(quad_mode),
        .sig_fail(sig_fail), .done(done)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flash content: probe word at 0x20..0x23 per stub mode, elsewhere an address hash.
    int stub_mode = 0;
    function automatic logic [7:0] mem_byte(input int mode, input int a);
        logic [7:0] v;
        v = 8'((a * 27 + 53) ^ (a >> 2));
        case (a)
            32'h20: v = (mode == 2) ? 8'h67 : 8'h66;
            32'h21: v = 8'h55;
            32'h22: v = 8'h99;
            32'h23: v = (mode == 1) ? 8'hAB : 8'hAA;
            default: ;
        endcase
        return v;
    endfunction

    // Flash stub: capture command bits on rising edges, log each transaction at deselect.
    int          st_n = 0, tx_n = 0;
    logic [31:0] st_cmd = '0;
    logic [7:0]  log_op [8];
    logic [23:0] log_addr [8];
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            if (st_n > 0) begin
                if (tx_n < 8) begin
                    log_op[tx_n]   = st_cmd[31:24];
                    log_addr[tx_n] = st_cmd[23:0];
                end
                tx_n++;
            end
            st_n   = 0;
            st_cmd = '0;
            d_in   = 4'h0;
        end else begin
            if (st_n < 32) st_cmd = {st_cmd[30:0], d_out[0]};
            st_n++;
        end
    end

    // Flash stub: drive read data after falling edges.
    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            if (st_cmd[31:24] == 8'h03 && st_n >= 32) begin
                automatic int j = st_n - 32;
                automatic logic [7:0] b = mem_byte(stub_mode, int'(st_cmd[23:0]) + j / 8);
                d_in = {2'b00, b[7 - (j % 8)], 1'b0};
            end else if (st_cmd[31:24] == 8'h6B && st_n >= 40) begin
                automatic int j = st_n - 40;
                automatic logic [7:0] b = mem_byte(stub_mode, int'(st_cmd[23:0]) + j / 2);
                d_in = (j % 2 == 0) ? b[7:4] : b[3:0];
            end
        end
    end

    // Pin monitors, sampled on the falling system clock edge.
    int   half0 = 0, half1 = 0;
    int   hcnt = 0, mon_edges = 0, gap_cnt = 0, gap_min = 0;
    int   hp_bad = 0, d0_bad = 0, oe_bad = 0, done_cnt = 0, done_bad = 0, hb_cnt = 0, hb_bad = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_d0 = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) begin
                if (sclk && !prev_sclk) mon_edges++;
                if (sclk) hcnt++;
                if (!sclk && prev_sclk && hcnt != ((tx_n == 0) ? half0 : half1)) hp_bad++;
                if (!sclk) hcnt = 0;
                if (sclk && d_out[0] !== prev_d0) d0_bad++;
                if (d_oe !== {3'b000, (mon_edges < 32) || (mon_edges == 32 && sclk)}) oe_bad++;
                if (prev_cs && tx_n > 0 && gap_cnt < gap_min) gap_min = gap_cnt;
                gap_cnt = 0;
            end else begin
                mon_edges = 0;
                hcnt = 0;
                gap_cnt++;
                if (d_oe !== 4'h0) oe_bad++;
            end
            if (done) begin
                done_cnt++;
                if (cs_n !== 1'b1) done_bad++;
            end
            if (hdr_valid) begin
                if (hdr_byte !== mem_byte(stub_mode, 32'h1D + hb_cnt)) hb_bad++;
                hb_cnt++;
            end
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
        prev_d0   = d_out[0];
    end

    task automatic clear_mon();
        tx_n = 0; hp_bad = 0; d0_bad = 0; oe_bad = 0; done_cnt = 0; done_bad = 0;
        hb_cnt = 0; hb_bad = 0; gap_min = 1000000;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000 && done_cnt == 0; k++) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // Vector: {probe mode, div_slow, div_fast, expected quad}
    localparam int NV = 5;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 8'd3, 8'd0, 1'b1},
        {2'd1, 8'd2, 8'd1, 1'b0},
        {2'd0, 8'd0, 8'd2, 1'b1},
        {2'd2, 8'd1, 8'd0, 1'b0},
        {2'd0, 8'd5, 8'd1, 1'b1}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R10: state held in reset
        chk(cs_n === 1'b1 && sclk === 1'b0, "R10 reset pins", {cs_n, sclk}, 2'b10);
        chk(d_oe === 4'h0 && hdr_valid === 1'b0 && done === 1'b0, "R10 reset outputs",
            {d_oe, hdr_valid, done}, 0);
        chk(quad_mode === 1'b0 && sig_fail === 1'b0, "R10 reset flags", {quad_mode, sig_fail}, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            automatic int  m  = int'(VEC[v][18:17]);
            automatic int  ds = int'(VEC[v][16:9]);
            automatic int  df = int'(VEC[v][8:1]);
            automatic bit  eq = VEC[v][0];
            stub_mode = m; div_slow = 8'(ds); div_fast = 8'(df);
            half0 = ds + 1;
            half1 = eq ? df + 1 : ds + 1;
            clear_mon();
            pulse_start();
            wait_done();
            chk(tx_n == 2, "R7 two transactions", tx_n, 2);
            chk(log_op[0] == 8'h03 && log_addr[0] == 24'h20, "R1 probe command",
                {log_op[0], log_addr[0]}, 32'h03000020);
            chk(log_op[1] == (eq ? 8'h6B : 8'h03) && log_addr[1] == 24'h1D,
                eq ? "R3 quad header command" : "R5 fallback header command",
                {log_op[1], log_addr[1]}, {(eq ? 8'h6B : 8'h03), 24'h1D});
            chk(quad_mode === eq, "R2 quad decision", quad_mode, eq);
            chk(sig_fail === !eq, "R5 fail flag", sig_fail, !eq);
            chk(hb_cnt == 41 && hb_bad == 0, "R4 header bytes", hb_cnt * 256 + hb_bad, 41 * 256);
            chk(hp_bad == 0, "R8 clock half period", hp_bad, 0);
            chk(d0_bad == 0, "R6 lane 0 timing", d0_bad, 0);
            chk(oe_bad == 0, "R11 lane enables", oe_bad, 0);
            chk(gap_min >= 2 * (ds + 1), "R7 deselect gap", gap_min, 2 * (ds + 1));
            chk(done_cnt == 1 && done_bad == 0, "R9 done pulse", done_cnt, 1);
        end

        // R9: a second start during the fetch is ignored
        stub_mode = 0; div_slow = 8'd1; div_fast = 8'd0;
        half0 = 2; half1 = 1;
        clear_mon();
        pulse_start();
        repeat (300) @(negedge clk);
        pulse_start();
        wait_done();
        repeat (60) @(negedge clk);
        chk(tx_n == 2 && done_cnt == 1, "R9 start while busy", tx_n * 16 + done_cnt, 2 * 16 + 1);
        chk(hb_cnt == 41 && hb_bad == 0, "R9 header intact", hb_cnt * 256 + hb_bad, 41 * 256);

        // R10: reset in the middle of a transaction
        clear_mon();
        pulse_start();
        repeat (250) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && d_oe === 4'h0, "R10 mid-run reset pins",
            {cs_n, sclk, d_oe}, 6'b100000);
        chk(quad_mode === 1'b0 && done === 1'b0 && hdr_valid === 1'b0, "R10 mid-run reset flags",
            {quad_mode, done, hdr_valid}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Recovery after reset: mismatched probe at divider zero.
        stub_mode = 1; div_slow = 8'd0; div_fast = 8'd3;
        half0 = 1; half1 = 1;
        clear_mon();
        pulse_start();
        wait_done();
        chk(sig_fail === 1'b1 && quad_mode === 1'b0, "R5 fallback after reset",
            {sig_fail, quad_mode}, 2'b10);
        chk(hb_cnt == 41 && hb_bad == 0 && hp_bad == 0, "R8 slow rate kept in fallback",
            hb_bad + hp_bad + (41 - hb_cnt), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule